// File: doc/BRIEF.md
# Table-Driven Control-Flow Watchdog Checker

This block runs beside a main processor and checks that the program it executes follows its control-flow graph. The program sends a 16-bit signature at the start of each branch-free block. Before checking starts, a loader port fills two on-chip tables. A state table gives each signature a base pointer and an entry count. These point into a successor memory that lists the signatures allowed to come next. Each subroutine has its own subgraph, and the subroutine is named by a field inside every signature.

A plain signature passes only if it appears in the successor list of the current signature. The block checks membership only, not which branch was taken. The list is scanned one entry per clock, and the block is ready for the next signature only when the scan ends. A call signature saves the current signature on a 16-entry stack and moves checking into the callee's subgraph. A return signature must carry the same subroutine field as the current signature. If it does, the saved caller signature is restored and checking resumes from it.

The first violation stops the block. It raises an error flag with a cause code, and both hold until reset. Table contents are not cleared by reset, so one load can serve several runs.

Top module: `cfw_checker`

## Requirements
- R1: A loader write (`ld_valid` high at a clock edge) stores `ld_data` into successor memory entry `ld_addr` when `ld_sel` is 0. When `ld_sel` is 1, it stores a state-table entry at index `ld_addr[5:0]`: bits [7:0] are the base pointer and bits [12:8] are the entry count. Later checks use the new contents.
- R2: After reset, `sig_ready` is 1, `err_flag` is 0 and `err_code` is 0. The first signature accepted that is not a return becomes the current state without any check and without a scan.
- R3: The signature kind sits in bits [15:14]: 01 is a call, 10 is a return, and 00 or 11 is plain. The subroutine field is bits [13:8]. A signature's state-table index is {bits[10:8], bits[2:0]}. A plain signature is accepted, and becomes the current state, only if it equals one of the `count` successor entries that start at the current state's base pointer.
- R4: The scan reads one successor entry per clock, and `sig_ready` is low while it runs. A match at list position i (0-based) returns `sig_ready` i+1 cycles after acceptance. A miss raises the error after `count` cycles, or after 1 cycle when `count` is 0.
- R5: A call signature, accepted with the stack not full, pushes the current state and becomes the current state without a scan. `sig_ready` stays high.
- R6: A return signature whose subroutine field equals the current state's, accepted with the stack not empty, restores the most recently pushed state as the current state. The following signatures are checked against that state's list.
- R7: A return signature whose subroutine field differs from the current state's, with the stack not empty, raises error code 2 in the cycle after acceptance.
- R8: A call signature accepted when 16 states are already stacked raises error code 3.
- R9: A return signature accepted with an empty stack raises error code 4. This takes priority over the subroutine-field comparison.
- R10: A scan that finds no match raises error code 1. The first error sets `err_flag` and its code. Both hold, `sig_ready` stays low and later signatures are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Loader write strobe |
| ld_sel | input | 1 | Loader target: 0 successor memory, 1 state table |
| ld_addr | input | 8 | Loader address |
| ld_data | input | 16 | Loader write data |
| sig_valid | input | 1 | Signature offered by the main processor |
| sig_data | input | 16 | Signature value |
| sig_ready | output | 1 | Checker can take a signature this cycle |
| err_flag | output | 1 | A control-flow violation has been seen |
| err_code | output | 3 | Cause: 0 none, 1 bad successor, 2 wrong return, 3 stack overflow, 4 stack underflow |

## Verification
The bench measures how long `sig_ready` stays low for each accepted signature, and so checks the scan as well as the verdict:
- Matches at list positions 0 and 1 show that the scan stops early and at the right entry.
- A miss over a two-entry list and a miss over an empty list show the full-length and zero-length cases.
- A call, a callee step, a matching return and then a step that is legal only from the caller show that the saved state is really restored.
- Return signatures with a foreign subroutine field, with and without stacked states, separate the wrong-return case from underflow.
- Sixteen calls followed by a seventeenth locate the exact overflow boundary.
- Rewriting single table entries shows that verdicts follow the loaded contents.

// File: rtl/cfw_pkg.sv
package cfw_pkg;

    localparam int SIG_W   = 16;
    localparam int KIND_HI = 15;
    localparam int KIND_LO = 14;
    localparam int SUB_HI  = 13;
    localparam int SUB_LO  = 8;

    typedef enum logic [1:0] {
        K_PLAIN = 2'b00,
        K_CALL  = 2'b01,
        K_RET   = 2'b10,
        K_ALT   = 2'b11
    } kind_e;

    typedef enum logic [2:0] {
        E_NONE  = 3'd0,
        E_SUCC  = 3'd1,
        E_RET   = 3'd2,
        E_OVF   = 3'd3,
        E_UNF   = 3'd4
    } err_e;

    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,
        PH_SCAN = 2'd1,
        PH_HALT = 2'd2
    } phase_e;

endpackage

// File: rtl/cfw_succ_table.sv
module cfw_succ_table
    import cfw_pkg::*;
#(
    parameter int SUCC_DEPTH = 256,
    parameter int PTR_W      = 8,
    parameter int ST_IDX_W   = 6,
    parameter int CNT_W      = 5
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [PTR_W-1:0]    wr_addr,
    input  logic [SIG_W-1:0]    wr_data,
    input  logic [ST_IDX_W-1:0] st_idx,
    input  logic [PTR_W-1:0]    rd_ptr,
    output logic [PTR_W-1:0]    st_base,
    output logic [CNT_W-1:0]    st_cnt,
    output logic [SIG_W-1:0]    rd_sig
);

    localparam int STATES  = 1 << ST_IDX_W;
    localparam int ENTRY_W = PTR_W + CNT_W;

    logic [SIG_W-1:0]   succ_mem [SUCC_DEPTH];
    logic [ENTRY_W-1:0] state_mem [STATES];

    // Tables keep their contents across reset; only the loader changes them.
    always_ff @(posedge clk) begin
        if (wr_en && !wr_sel) begin
            succ_mem[wr_addr] <= wr_data;
        end
        if (wr_en && wr_sel) begin
            state_mem[wr_addr[ST_IDX_W-1:0]] <= wr_data[ENTRY_W-1:0];
        end
    end

    always_comb begin
        st_base = state_mem[st_idx][PTR_W-1:0];
        st_cnt  = state_mem[st_idx][ENTRY_W-1:PTR_W];
        rd_sig  = succ_mem[rd_ptr];
    end

endmodule

// File: rtl/cfw_call_stack.sv
module cfw_call_stack
    import cfw_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [SIG_W-1:0] push_data,
    output logic [SIG_W-1:0] top_data,
    output logic             empty,
    output logic             full
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } stk_t;

    stk_t s_d, s_q;
    logic [SIG_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0] top_idx;

    always_comb begin
        s_d     = s_q;
        top_idx = IDX_W'(s_q.cnt - 1'b1);
        if (push && (s_q.cnt != CW'(DEPTH))) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end else if (pop && (s_q.cnt != '0)) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push && (s_q.cnt != CW'(DEPTH))) begin
            mem[s_q.cnt[IDX_W-1:0]] <= push_data;
        end
    end

    assign top_data = mem[top_idx];
    assign empty    = (s_q.cnt == '0);
    assign full     = (s_q.cnt == CW'(DEPTH));

    // R8: a push on a full stack leaves the depth unchanged
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> $stable(s_q.cnt));

    // R9: a pop on an empty stack leaves the depth unchanged
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> $stable(s_q.cnt));

    // R5: a push on a stack with room deepens it by one
    p_push_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full) |=> (s_q.cnt == $past(s_q.cnt) + 1'b1));

    p_one_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

endmodule

// File: rtl/cfw_seq.sv
module cfw_seq
    import cfw_pkg::*;
#(
    parameter int PTR_W      = 8,
    parameter int CNT_W      = 5,
    parameter int SUB_IDX_W  = 3,
    parameter int NODE_IDX_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sig_valid,
    input  logic [SIG_W-1:0]               sig_data,
    input  logic [PTR_W-1:0]               st_base,
    input  logic [CNT_W-1:0]               st_cnt,
    input  logic [SIG_W-1:0]               rd_sig,
    input  logic [SIG_W-1:0]               stk_top,
    input  logic                           stk_empty,
    input  logic                           stk_full,
    output logic [SUB_IDX_W+NODE_IDX_W-1:0] st_idx,
    output logic [PTR_W-1:0]               rd_ptr,
    output logic                           push,
    output logic                           pop,
    output logic [SIG_W-1:0]               push_data,
    output logic                           sig_ready,
    output logic                           err_flag,
    output logic [2:0]                     err_code
);

    typedef struct packed {
        phase_e           phase;
        logic             started;
        logic [SIG_W-1:0] cur;
        logic [SIG_W-1:0] cand;
        logic [PTR_W-1:0] ptr;
        logic [CNT_W-1:0] left;
        err_e             code;
    } seq_t;

    seq_t q, d;
    logic [1:0] in_kind;
    logic       same_sub;

    always_comb begin
        d         = q;
        push      = 1'b0;
        pop       = 1'b0;
        push_data = q.cur;
        in_kind   = sig_data[KIND_HI:KIND_LO];
        same_sub  = (sig_data[SUB_HI:SUB_LO] == q.cur[SUB_HI:SUB_LO]);

        unique case (q.phase)
            PH_WAIT: begin
                if (sig_valid) begin
                    if (in_kind == K_RET) begin
                        if (stk_empty) begin
                            d.code  = E_UNF;
                            d.phase = PH_HALT;
                        end else if (!same_sub) begin
                            d.code  = E_RET;
                            d.phase = PH_HALT;
                        end else begin
                            pop   = 1'b1;
                            d.cur = stk_top;
                        end
                    end else if (!q.started) begin
                        d.cur     = sig_data;
                        d.started = 1'b1;
                    end else if (in_kind == K_CALL) begin
                        if (stk_full) begin
                            d.code  = E_OVF;
                            d.phase = PH_HALT;
                        end else begin
                            push  = 1'b1;
                            d.cur = sig_data;
                        end
                    end else begin
                        d.cand  = sig_data;
                        d.ptr   = st_base;
                        d.left  = st_cnt;
                        d.phase = PH_SCAN;
                    end
                end
            end
            PH_SCAN: begin
                if (q.left == '0) begin
                    d.code  = E_SUCC;
                    d.phase = PH_HALT;
                end else if (rd_sig == q.cand) begin
                    d.cur   = q.cand;
                    d.phase = PH_WAIT;
                end else if (q.left == CNT_W'(1)) begin
                    d.code  = E_SUCC;
                    d.phase = PH_HALT;
                end else begin
                    d.ptr  = q.ptr + 1'b1;
                    d.left = q.left - 1'b1;
                end
            end
            default: begin
                d = q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.phase   <= PH_WAIT;
            q.started <= 1'b0;
            q.cur     <= '0;
            q.cand    <= '0;
            q.ptr     <= '0;
            q.left    <= '0;
            q.code    <= E_NONE;
        end else begin
            q <= d;
        end
    end

    assign st_idx    = {q.cur[SUB_LO+SUB_IDX_W-1:SUB_LO], q.cur[NODE_IDX_W-1:0]};
    assign rd_ptr    = q.ptr;
    assign sig_ready = (q.phase == PH_WAIT);
    assign err_flag  = (q.phase == PH_HALT);
    assign err_code  = q.code;

    // R10: the first error and its cause hold until reset
    p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> (err_flag && $stable(err_code)));

    // R10: once halted, no stack traffic happens
    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (!push && !pop));

    // R10: the code is non-zero exactly while the flag is set
    p_code_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag == (err_code != E_NONE));

    // R4: each scan cycle that does not end the scan consumes exactly one entry
    p_scan_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_SCAN) |=> ((q.phase != PH_SCAN) ||
            ((q.left == $past(q.left) - 1'b1) && (q.ptr == $past(q.ptr) + 1'b1))));

    // R3: leaving a scan without an error adopts the candidate as the current state
    p_scan_adopt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.phase == PH_SCAN) && (d.phase == PH_WAIT)) |=> (q.cur == $past(q.cand)));

endmodule

// File: rtl/cfw_checker.sv
module cfw_checker
    import cfw_pkg::*;
#(
    parameter int SUCC_DEPTH  = 256,
    parameter int STACK_DEPTH = 16,
    parameter int CNT_W       = 5,
    parameter int SUB_IDX_W   = 3,
    parameter int NODE_IDX_W  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ld_valid,
    input  logic        ld_sel,
    input  logic [7:0]  ld_addr,
    input  logic [15:0] ld_data,
    input  logic        sig_valid,
    input  logic [15:0] sig_data,
    output logic        sig_ready,
    output logic        err_flag,
    output logic [2:0]  err_code
);

    localparam int PTR_W    = $clog2(SUCC_DEPTH);
    localparam int ST_IDX_W = SUB_IDX_W + NODE_IDX_W;

    logic [ST_IDX_W-1:0] st_idx;
    logic [PTR_W-1:0]    st_base;
    logic [CNT_W-1:0]    st_cnt;
    logic [PTR_W-1:0]    rd_ptr;
    logic [SIG_W-1:0]    rd_sig;
    logic [SIG_W-1:0]    stk_top;
    logic [SIG_W-1:0]    push_data;
    logic                stk_empty;
    logic                stk_full;
    logic                push;
    logic                pop;

    cfw_succ_table #(
        .SUCC_DEPTH (SUCC_DEPTH),
        .PTR_W      (PTR_W),
        .ST_IDX_W   (ST_IDX_W),
        .CNT_W      (CNT_W)
    ) u_table (
        .clk     (clk),
        .wr_en   (ld_valid),
        .wr_sel  (ld_sel),
        .wr_addr (ld_addr[PTR_W-1:0]),
        .wr_data (ld_data),
        .st_idx  (st_idx),
        .rd_ptr  (rd_ptr),
        .st_base (st_base),
        .st_cnt  (st_cnt),
        .rd_sig  (rd_sig)
    );

    cfw_call_stack #(
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_data (push_data),
        .top_data  (stk_top),
        .empty     (stk_empty),
        .full      (stk_full)
    );

    cfw_seq #(
        .PTR_W      (PTR_W),
        .CNT_W      (CNT_W),
        .SUB_IDX_W  (SUB_IDX_W),
        .NODE_IDX_W (NODE_IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_valid (sig_valid),
        .sig_data  (sig_data),
        .st_base   (st_base),
        .st_cnt    (st_cnt),
        .rd_sig    (rd_sig),
        .stk_top   (stk_top),
        .stk_empty (stk_empty),
        .stk_full  (stk_full),
        .st_idx    (st_idx),
        .rd_ptr    (rd_ptr),
        .push      (push),
        .pop       (pop),
        .push_data (push_data),
        .sig_ready (sig_ready),
        .err_flag  (err_flag),
        .err_code  (err_code)
    );

    // R9: a return with nothing stacked must not pop
    p_ret_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop |-> !stk_empty));

endmodule

// File: tb/cfw_checker_bench.sv
module cfw_checker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic        ld_sel = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic        sig_valid = 1'b0;
    logic [15:0] sig_data = '0;
    logic        sig_ready;
    logic        err_flag;
    logic [2:0]  err_code;

    int n_checks = 0;
    int n_fail   = 0;
    int busy     = 0;

    localparam logic [15:0] SA   = 16'h0001;
    localparam logic [15:0] SB   = 16'h0002;
    localparam logic [15:0] SC   = 16'h0003;
    localparam logic [15:0] SBAD = 16'h0004;
    localparam logic [15:0] CALL1 = 16'h4100;
    localparam logic [15:0] SX   = 16'h0101;
    localparam logic [15:0] RET1 = 16'h8102;

    always #5 clk = ~clk;

    cfw_checker u_cfw_checker (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .ld_sel    (ld_sel),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .sig_valid (sig_valid),
        .sig_data  (sig_data),
        .sig_ready (sig_ready),
        .err_flag  (err_flag),
        .err_code  (err_code)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sig_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load(input bit sel, input logic [7:0] addr, input logic [15:0] data);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_sel   = sel;
        ld_addr  = addr;
        ld_data  = data;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    // Offers one signature, then counts the negedges with sig_ready low.
    task automatic send(input logic [15:0] s);
        @(negedge clk);
        while (!sig_ready && !err_flag) @(negedge clk);
        sig_valid = 1'b1;
        sig_data  = s;
        @(negedge clk);
        sig_valid = 1'b0;
        busy = 0;
        while (!sig_ready && !err_flag) begin
            busy++;
            @(negedge clk);
        end
    endtask

    task automatic load_graph();
        load(1'b0, 8'd0,  SC);
        load(1'b0, 8'd1,  SB);
        load(1'b0, 8'd4,  SC);
        load(1'b0, 8'd12, SX);
        load(1'b0, 8'd16, 16'h0105);
        load(1'b0, 8'd17, 16'h0106);
        load(1'b0, 8'd18, RET1);
        load(1'b1, 8'd1,  16'h0200);  // A: count 2, base 0
        load(1'b1, 8'd2,  16'h0104);  // B: count 1, base 4
        load(1'b1, 8'd3,  16'h0000);  // C: count 0
        load(1'b1, 8'd8,  16'h010C);  // call target: count 1, base 12
        load(1'b1, 8'd9,  16'h0310);  // X: count 3, base 16
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        check(sig_ready == 1'b1, "R2 ready after reset", int'(sig_ready), 1);
        check(err_flag == 1'b0 && err_code == 3'd0, "R2 error clear after reset",
              int'(err_code), 0);
    endtask

    task automatic t_legal_path();
        do_reset();
        send(SA);
        check(busy == 0, "R2 first signature seeds without scan", busy, 0);
        send(SB);
        check(busy == 2, "R4 match at position 1 takes 2 cycles", busy, 2);
        check(!err_flag, "R3 listed successor accepted", int'(err_code), 0);
        send(CALL1);
        check(busy == 0 && !err_flag, "R5 call accepted without scan", busy, 0);
        send(SX);
        check(busy == 1 && !err_flag, "R4 callee step at position 0", busy, 1);
        send(RET1);
        check(busy == 0 && !err_flag, "R6 matching return accepted", int'(err_code), 0);
        send(SC);
        check(busy == 1 && !err_flag, "R6 caller state restored after return", int'(err_code), 0);
    endtask

    task automatic t_bad_successor();
        do_reset();
        send(SA);
        send(SBAD);
        check(busy == 2, "R4 miss over two entries takes 2 cycles", busy, 2);
        check(err_flag && err_code == 3'd1, "R10 bad successor code", int'(err_code), 1);
        // Further signatures are ignored while halted.
        @(negedge clk);
        sig_valid = 1'b1;
        sig_data  = 16'h8000;
        repeat (5) @(negedge clk);
        sig_valid = 1'b0;
        check(!sig_ready, "R10 ready stays low after error", int'(sig_ready), 0);
        check(err_code == 3'd1, "R10 code held after further input", int'(err_code), 1);
        do_reset();
        @(negedge clk);
        check(!err_flag && sig_ready, "R10 reset clears error", int'(err_code), 0);
    endtask

    task automatic t_empty_list();
        do_reset();
        send(SC);
        send(SA);
        check(busy == 1, "R4 empty list fails after 1 cycle", busy, 1);
        check(err_code == 3'd1, "R10 empty list code", int'(err_code), 1);
    endtask

    task automatic t_wrong_return();
        do_reset();
        send(SA);
        send(CALL1);
        send(SX);
        send(16'h8200);
        check(busy == 0 && err_code == 3'd2, "R7 wrong-subroutine return code", int'(err_code), 2);
    endtask

    task automatic t_underflow();
        do_reset();
        send(SA);
        send(16'h8000);
        check(err_code == 3'd4, "R9 return on empty stack", int'(err_code), 4);
        do_reset();
        send(SA);
        send(16'h8300);
        check(err_code == 3'd4, "R9 underflow beats subroutine compare", int'(err_code), 4);
    endtask

    task automatic t_overflow();
        do_reset();
        send(SA);
        for (int i = 0; i < 16; i++) send(CALL1);
        check(!err_flag, "R8 sixteen calls fit", int'(err_code), 0);
        send(CALL1);
        check(err_code == 3'd3, "R8 seventeenth call overflows", int'(err_code), 3);
    endtask

    task automatic t_reload();
        load(1'b0, 8'd0, SB);
        do_reset();
        send(SA);
        send(SB);
        check(busy == 1 && !err_flag, "R1 rewritten successor entry used", busy, 1);
        load(1'b0, 8'd0, SC);
        load(1'b1, 8'd1, 16'h0100);
        do_reset();
        send(SA);
        send(SB);
        check(busy == 1 && err_code == 3'd1, "R1 shortened count rejects old entry",
              int'(err_code), 1);
        load(1'b1, 8'd1, 16'h0200);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        load_graph();
        t_reset_state();
        t_legal_path();
        t_bad_successor();
        t_empty_list();
        t_wrong_return();
        t_underflow();
        t_overflow();
        t_reload();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule